// File: doc/BRIEF.md
# Transceiver Direction Enable Controller

This block sits beside one UART channel and produces the driver-enable and receiver-enable levels that an RS-422 or RS-485 transceiver needs on a half-duplex link. The board then needs no external gating to turn the line around. The UART transmitter supplies a single `tx_active` level. It is high from the start of the first start bit until the end of the final stop bit, and it stays high across back-to-back characters. From that level the block derives a transmit enable (TXEN) and a receive enable (RXEN). Each enable has its own programmable active level and its own choice between a fixed level and toggling with transmitter activity.

The device has no dedicated pins for these enables. They are routed onto pins that normally carry the modem-control outputs (RTS, DTR) or the FIFO status flags (TXRDY, RXRDY). A two-bit pin-select field chooses which pins carry them. Pins that are not selected pass their normal signal through unchanged.

The build parameter `HAS_RDY_PINS` states whether the package brings out the two FIFO status pins. Without them, the setting that routes the enables to those pins acts like the "no enables" setting. All settings live in one 8-bit control register on a simple write/read bus. Every pin output is registered, so a change of mode or pin assignment cannot produce a combinational glitch.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst_n` is low, the control register reads 0x80 and the pins drive `rts_txen_pin`=1, `dtr_txen_pin`=1, `txrdy_txen_pin`=0 and `rxrdy_rxen_pin`=0. These values remain until the first clock edge with `rst_n` high.
- R2: The control register layout is: bit 7 RXEN active level, bit 6 RXEN toggle enable, bit 5 TXEN active level, bit 4 TXEN toggle enable, bits 3:2 unused, bits 1:0 pin select. A write stores all bits except 3:2, which always read 0. The new value is visible on `cfg_rdata` after the write edge.
- R3: With bit 4 = 0, TXEN is constantly equal to bit 5, whatever `tx_active` does.
- R4: With bit 4 = 1, TXEN equals bit 5 while `tx_active` is 1 and equals the inverse of bit 5 while `tx_active` is 0.
- R5: With pin select 11 on a build with the status pins, RXEN appears on `rxrdy_rxen_pin`. With bit 6 = 0, RXEN is constantly bit 7. With bit 6 = 1, RXEN equals bit 7 while idle and its inverse while `tx_active` is 1.
- R6: Pin select 00 passes `rts_n_in`, `dtr_n_in`, `txrdy_in` and `rxrdy_in` to their four pins.
- R7: Pin select 01 drives TXEN on `rts_txen_pin`. The other three pins pass their normal inputs.
- R8: Pin select 10 drives TXEN on `dtr_txen_pin`. The other three pins pass their normal inputs.
- R9: Pin select 11 on a build with the status pins drives TXEN on `txrdy_txen_pin` and RXEN on `rxrdy_rxen_pin`, while RTS and DTR pass through.
- R10: On a build with `HAS_RDY_PINS`=0, pin select 11 gives the same pin behaviour as 00. The register still reads back the stored 11.
- R11: Each pin is registered. Its value after clock edge n is computed from the inputs and the control register as they were before edge n. A register write therefore reaches the pins one edge after the write edge.
- R12: Bits 7:6 have no effect on any pin unless pin select is 11 on a build with the status pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| tx_active | input | 1 | Transmitter is sending a character |
| rts_n_in | input | 1 | Normal RTS modem-control level |
| dtr_n_in | input | 1 | Normal DTR modem-control level |
| txrdy_in | input | 1 | Normal transmit FIFO ready flag |
| rxrdy_in | input | 1 | Normal receive FIFO ready flag |
| rts_txen_pin | output | 1 | RTS or TXEN pin |
| dtr_txen_pin | output | 1 | DTR or TXEN pin |
| txrdy_txen_pin | output | 1 | TXRDY or TXEN pin |
| rxrdy_rxen_pin | output | 1 | RXRDY or RXEN pin |

## Verification
The bound checker checks the following on every clock:
- the reserved bits read zero, and a write lands in the register one edge later;
- pass-through pins equal the previous cycle's inputs whenever the pin select leaves them normal;
- a fixed-level TXEN follows its active-level bit;
- a toggling TXEN takes its active level while sending;
- a fixed-level RXEN holds its bit on the status pin.

Some behaviours only the bench scenarios can show. These are the exact one-edge lag of a write at the pins, the fallback of setting 11 on a build without status pins, and the fact that the receive bits leave the pins untouched under the RTS and DTR settings. The bench checks them by running both builds side by side against a behavioural model across every pin-select value.

// File: rtl/rs485_dir_pkg.sv
// Package: shared types and constants for the transceiver direction
// controller. Assumes an 8-bit control register whose field positions are
// fixed by the software-visible layout.
package rs485_dir_pkg;

    localparam int CFG_W = 8;

    // Pin-select field encodings (bits 1:0 of the control register).
    typedef enum logic [1:0] {
        PINSEL_NONE = 2'b00,
        PINSEL_RTS  = 2'b01,
        PINSEL_DTR  = 2'b10,
        PINSEL_RDY  = 2'b11
    } pinsel_e;

    // Control register view, MSB first.
    typedef struct packed {
        logic       rx_level;
        logic       rx_toggle;
        logic       tx_level;
        logic       tx_toggle;
        logic [1:0] unused;
        pinsel_e    pinsel;
    } dir_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 8'h80;
    localparam logic [CFG_W-1:0] CFG_WMASK = 8'hF3;

    // Values the four pins take while reset is applied.
    localparam logic RTS_PIN_RESET   = 1'b1;
    localparam logic DTR_PIN_RESET   = 1'b1;
    localparam logic TXRDY_PIN_RESET = 1'b0;
    localparam logic RXRDY_PIN_RESET = 1'b0;

endpackage

// File: rtl/rs485_dir_cfg_reg.sv
// Module: control register. Holds the direction-control settings and masks
// the unused bits on every write, so they always read as zero.
// Assumes a single-register bus: a write strobe and data, with no address.
module rs485_dir_cfg_reg
    import rs485_dir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output dir_cfg_t         cfg,
    output logic [CFG_W-1:0] rdata
);

    logic [CFG_W-1:0] cfg_q;

    // Load masked write data, or the reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q <= wdata & CFG_WMASK;
        end
    end

    // Present the register as a struct and as raw read data.
    always_comb begin
        cfg   = dir_cfg_t'(cfg_q);
        rdata = cfg_q;
    end

endmodule

// File: rtl/rs485_dir_enable_gen.sv
// Module: derives the transmit and receive enable levels from transmitter
// activity and the level and toggle settings.
// Purely combinational; the pin stage registers the results.
module rs485_dir_enable_gen (
    input  logic tx_active,
    input  logic tx_level,
    input  logic tx_toggle,
    input  logic rx_level,
    input  logic rx_toggle,
    output logic txen,
    output logic rxen
);

    // TXEN is asserted while sending; when toggling, it is deasserted while idle.
    always_comb begin
        if (tx_toggle) begin
            txen = tx_active ? tx_level : ~tx_level;
        end else begin
            txen = tx_level;
        end
    end

    // RXEN is asserted while idle; when toggling, it is deasserted while sending.
    always_comb begin
        if (rx_toggle) begin
            rxen = tx_active ? ~rx_level : rx_level;
        end else begin
            rxen = rx_level;
        end
    end

endmodule

// File: rtl/rs485_dir_pin_mux.sv
// Module: selects, for each shared pin, either its normal signal or an
// enable, and registers the result.
// HAS_RDY_PINS=0 models a package without the status pins; the RDY
// selection then falls back to plain pass-through.
module rs485_dir_pin_mux
    import rs485_dir_pkg::*;
#(
    parameter bit HAS_RDY_PINS = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  pinsel_e pinsel,
    input  logic    txen,
    input  logic    rxen,
    input  logic    rts_n_in,
    input  logic    dtr_n_in,
    input  logic    txrdy_in,
    input  logic    rxrdy_in,
    output logic    rts_pin,
    output logic    dtr_pin,
    output logic    txrdy_pin,
    output logic    rxrdy_pin
);

    pinsel_e eff_sel;
    logic    rts_d, dtr_d, txrdy_d, rxrdy_d;

    // Resolve the effective selection for the configured package.
    generate
        if (HAS_RDY_PINS) begin : g_rdy_pins
            assign eff_sel = pinsel;
        end else begin : g_no_rdy_pins
            assign eff_sel = (pinsel == PINSEL_RDY) ? PINSEL_NONE : pinsel;
        end
    endgenerate

    // Choose the next value of each pin from the effective selection.
    always_comb begin
        rts_d   = rts_n_in;
        dtr_d   = dtr_n_in;
        txrdy_d = txrdy_in;
        rxrdy_d = rxrdy_in;
        unique case (eff_sel)
            PINSEL_RTS: rts_d = txen;
            PINSEL_DTR: dtr_d = txen;
            PINSEL_RDY: begin
                txrdy_d = txen;
                rxrdy_d = rxen;
            end
            default: ;
        endcase
    end

    // Register the pins so that selection changes cannot glitch them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_pin   <= RTS_PIN_RESET;
            dtr_pin   <= DTR_PIN_RESET;
            txrdy_pin <= TXRDY_PIN_RESET;
            rxrdy_pin <= RXRDY_PIN_RESET;
        end else begin
            rts_pin   <= rts_d;
            dtr_pin   <= dtr_d;
            txrdy_pin <= txrdy_d;
            rxrdy_pin <= rxrdy_d;
        end
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
// Module: top of the per-channel direction controller. Ties the control
// register, the enable generator and the registered pin multiplexer
// together. Assumes tx_active is synchronous to clk.
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter bit HAS_RDY_PINS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             tx_active,
    input  logic             rts_n_in,
    input  logic             dtr_n_in,
    input  logic             txrdy_in,
    input  logic             rxrdy_in,
    output logic             rts_txen_pin,
    output logic             dtr_txen_pin,
    output logic             txrdy_txen_pin,
    output logic             rxrdy_rxen_pin
);

    dir_cfg_t cfg;
    logic     txen;
    logic     rxen;

    rs485_dir_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    rs485_dir_enable_gen u_en (
        .tx_active (tx_active),
        .tx_level  (cfg.tx_level),
        .tx_toggle (cfg.tx_toggle),
        .rx_level  (cfg.rx_level),
        .rx_toggle (cfg.rx_toggle),
        .txen      (txen),
        .rxen      (rxen)
    );

    rs485_dir_pin_mux #(
        .HAS_RDY_PINS (HAS_RDY_PINS)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .pinsel    (cfg.pinsel),
        .txen      (txen),
        .rxen      (rxen),
        .rts_n_in  (rts_n_in),
        .dtr_n_in  (dtr_n_in),
        .txrdy_in  (txrdy_in),
        .rxrdy_in  (rxrdy_in),
        .rts_pin   (rts_txen_pin),
        .dtr_pin   (dtr_txen_pin),
        .txrdy_pin (txrdy_txen_pin),
        .rxrdy_pin (rxrdy_rxen_pin)
    );

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
// Module: assertion checker for rs485_dir_ctrl, bound to every instance.
// Observes ports only.
module rs485_dir_ctrl_chk #(
    parameter bit HAS_RDY_PINS = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       tx_active,
    input logic       rts_n_in,
    input logic       dtr_n_in,
    input logic       txrdy_in,
    input logic       rxrdy_in,
    input logic       rts_txen_pin,
    input logic       dtr_txen_pin,
    input logic       txrdy_txen_pin,
    input logic       rxrdy_rxen_pin
);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3:2] == 2'b00);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata == {$past(cfg_wdata[7:4]), 2'b00, $past(cfg_wdata[1:0])});

    // R6
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] == 2'b00) |=>
            (rts_txen_pin == $past(rts_n_in)) && (dtr_txen_pin == $past(dtr_n_in)) &&
            (txrdy_txen_pin == $past(txrdy_in)) && (rxrdy_rxen_pin == $past(rxrdy_in)));

    // R3
    txen_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] == 2'b01 && !cfg_rdata[4]) |=> rts_txen_pin == $past(cfg_rdata[5]));

    // R4
    txen_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] == 2'b10 && cfg_rdata[4] && tx_active) |=>
            dtr_txen_pin == $past(cfg_rdata[5]));

    // R9
    rdy_sel_modem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] == 2'b11) |=>
            (rts_txen_pin == $past(rts_n_in)) && (dtr_txen_pin == $past(dtr_n_in)));

    generate
        if (HAS_RDY_PINS) begin : g_rx_chk
            // R5
            rxen_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_rdata[1:0] == 2'b11 && !cfg_rdata[6]) |=>
                    rxrdy_rxen_pin == $past(cfg_rdata[7]));
        end else begin : g_fallback_chk
            // R10
            fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_rdata[1:0] == 2'b11) |=>
                    (txrdy_txen_pin == $past(txrdy_in)) && (rxrdy_rxen_pin == $past(rxrdy_in)));
        end
    endgenerate

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(
    .HAS_RDY_PINS (HAS_RDY_PINS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .tx_active      (tx_active),
    .rts_n_in       (rts_n_in),
    .dtr_n_in       (dtr_n_in),
    .txrdy_in       (txrdy_in),
    .rxrdy_in       (rxrdy_in),
    .rts_txen_pin   (rts_txen_pin),
    .dtr_txen_pin   (dtr_txen_pin),
    .txrdy_txen_pin (txrdy_txen_pin),
    .rxrdy_rxen_pin (rxrdy_rxen_pin)
);

// File: tb/rs485_dir_ctrl_bench.sv
// Bench: runs a build with status pins and one without, side by side,
// against a behavioural model that is compared on every clock.
module rs485_dir_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic       tx_active, rts_n_in, dtr_n_in, txrdy_in, rxrdy_in;
    logic [7:0] rdata_a, rdata_b;
    logic [3:0] pins_a, pins_b;   // {rts, dtr, txrdy, rxrdy}

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 1'b0;
    string phase  = "R1";

    // Model state
    logic [7:0] m_cfg;
    logic [3:0] m_pins_a, m_pins_b;

    always #2 clk = ~clk;   // 250 MHz

    rs485_dir_ctrl #(.HAS_RDY_PINS(1'b1)) u_rs485_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_a), .tx_active(tx_active), .rts_n_in(rts_n_in),
        .dtr_n_in(dtr_n_in), .txrdy_in(txrdy_in), .rxrdy_in(rxrdy_in),
        .rts_txen_pin(pins_a[3]), .dtr_txen_pin(pins_a[2]),
        .txrdy_txen_pin(pins_a[1]), .rxrdy_rxen_pin(pins_a[0]));

    rs485_dir_ctrl #(.HAS_RDY_PINS(1'b0)) u_rs485_dir_ctrl_nordy (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata_b), .tx_active(tx_active), .rts_n_in(rts_n_in),
        .dtr_n_in(dtr_n_in), .txrdy_in(txrdy_in), .rxrdy_in(rxrdy_in),
        .rts_txen_pin(pins_b[3]), .dtr_txen_pin(pins_b[2]),
        .txrdy_txen_pin(pins_b[1]), .rxrdy_rxen_pin(pins_b[0]));

    // Expected pin values from the requirements.
    function automatic logic [3:0] expect_pins(logic [7:0] c, bit has_rdy);
        logic       txen, rxen;
        logic [1:0] sel;
        logic [3:0] p;
        txen = c[4] ? (tx_active ? c[5] : ~c[5]) : c[5];
        rxen = c[6] ? (tx_active ? ~c[7] : c[7]) : c[7];
        sel  = c[1:0];
        if (!has_rdy && sel == 2'b11) sel = 2'b00;
        p = {rts_n_in, dtr_n_in, txrdy_in, rxrdy_in};
        if (sel == 2'b01) p[3] = txen;
        if (sel == 2'b10) p[2] = txen;
        if (sel == 2'b11) begin
            p[1] = txen;
            p[0] = rxen;
        end
        return p;
    endfunction

    // Advance the model at each edge, using the pre-edge register value.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg    = 8'h80;
            m_pins_a = 4'b1100;
            m_pins_b = 4'b1100;
        end else begin
            m_pins_a = expect_pins(m_cfg, 1'b1);
            m_pins_b = expect_pins(m_cfg, 1'b0);
            if (cfg_wr) m_cfg = cfg_wdata & 8'hF3;
        end
    end

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare both builds against the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            check(phase, "rdata", rdata_a, m_cfg);
            check(phase, "rdata nordy", rdata_b, m_cfg);
            check(phase, "pins", {4'h0, pins_a}, {4'h0, m_pins_a});
            check((m_cfg[1:0] == 2'b11) ? "R10" : phase, "pins nordy",
                  {4'h0, pins_b}, {4'h0, m_pins_b});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_cfg(logic [7:0] v);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic churn(int n);
        for (int i = 0; i < n; i++) begin
            {tx_active, rts_n_in, dtr_n_in, txrdy_in, rxrdy_in} = 5'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = 8'h00;
        {tx_active, rts_n_in, dtr_n_in, txrdy_in, rxrdy_in} = 5'b00000;
        phase = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state, checked directly as well
        check("R1", "reset rdata", rdata_a, 8'h80);
        check("R1", "reset pins", {4'h0, pins_a}, 8'h0C);
        rst_n = 1'b1;
        phase = "R6";
        churn(40);
        // R11: write lands one edge later at the pins
        phase = "R11";
        tx_active = 1'b0; rts_n_in = 1'b0;
        write_cfg(8'h21);
        check("R11", "rts pin right after write", {7'h0, pins_a[3]}, 8'h00);
        @(negedge clk);
        check("R11", "rts pin one edge later", {7'h0, pins_a[3]}, 8'h01);
        phase = "R3"; churn(30);                          // R3, R7: fixed TXEN on RTS
        phase = "R7"; write_cfg(8'h01); churn(30);
        phase = "R4"; write_cfg(8'h11); churn(40);        // toggling, active low
        phase = "R8"; write_cfg(8'h32); churn(40);        // TXEN on DTR, toggling
        phase = "R12"; write_cfg(8'hC2); churn(30);       // RX bits ignored
        write_cfg(8'h41); churn(30);
        phase = "R2"; write_cfg(8'hFF); churn(2);         // bits 3:2 read 0
        check("R2", "readback", rdata_a, 8'hF3);
        phase = "R9"; churn(40);                          // enables on status pins
        phase = "R5"; write_cfg(8'h33); churn(30);        // fixed RXEN low
        write_cfg(8'hD3); churn(40);                      // toggling RXEN
        phase = "R6"; write_cfg(8'h00); churn(20);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule